// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a low-latency DRAM interface and owns the command pins from power-on until the memory is ready. It keeps the device deselected until a power-good indication reports that the supplies and the clock are stable. It then drives an unbroken stream of NOP commands for a minimum idle time, counted in clock cycles from a clock-frequency parameter. After that it issues a back-to-back burst of mode-register-set commands, which resets the memory's internal logic. The burst is made of a parameterized number of dummy commands, each with the address bus at zero, and ends with one real command that carries the configured mode value.

After the real command, the sequencer waits out a parameterized mode-register cycle time with NOPs and then raises `init_done`. From that point the command pins are left deselected, and the normal controller takes them over. The mode value is sampled once, on the cycle the sequence starts, so later changes on that input do not alter the programmed word. A loss of power-good, or the asynchronous reset, drops the machine straight back to its waiting state.

Top module: `dram_init_seq`

## Requirements
- R1: While reset is held, and afterwards while `pwr_good` stays low, the pins read deselected: `cs_n`=1, `we_n`=1, `ref_n`=1, `addr`=0 and `init_done`=0.
- R2: Only two active commands are ever driven, both active-low: NOP is `cs_n`=0, `we_n`=1, `ref_n`=1, and mode-register-set is `cs_n`=0, `we_n`=0, `ref_n`=0. Every cycle with `cs_n`=0 has `we_n` equal to `ref_n`.
- R3: Suppose `pwr_good` is sampled high at a clock edge while the machine waits. The outputs then show NOP from that edge onwards for exactly CLK_FREQ_MHZ*IDLE_US cycles, with `addr`=0.
- R4: The idle period is followed on the very next cycle by NUM_DUMMY mode-register-set commands on consecutive cycles, each with `addr`=0. NUM_DUMMY must be at least 2.
- R5: On the cycle directly after the last dummy comes one mode-register-set with `addr` equal to the `mode_val` sampled on the start edge. Changes to `mode_val` after that edge have no effect.
- R6: After the valid command come exactly MRSC_CYCLES NOP cycles with `addr`=0. Then `init_done` rises, and from the same cycle the command pins read deselected.
- R7: Once high, `init_done` stays high, with the pins deselected, for as long as `pwr_good` stays high and reset is not applied.
- R8: If `pwr_good` is sampled low at any edge, that edge makes the outputs deselected with `init_done`=0. A later rise of `pwr_good` starts the whole sequence again from R3.
- R9: Asserting `rst_n` low deselects the pins and clears `init_done` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_good | input | 1 | Supplies and clock stable; synchronous to clk |
| mode_val | input | ADDR_W | Mode word to program with the valid command |
| cs_n | output | 1 | Chip select, active low |
| we_n | output | 1 | Write enable, active low |
| ref_n | output | 1 | Refresh strobe, active low |
| addr | output | ADDR_W | Address bus to the memory |
| init_done | output | 1 | Initialization complete; controller may take the pins |

## Verification
The case that is hardest to reach from the ports is an interrupted sequence followed by a clean restart. In that case nothing left over from the aborted run may leak into the next one: no partly spent idle count and no stale mode word. The stimulus drops `pwr_good` part-way through the idle phase and checks the deselect on the next cycle. It then starts again and changes `mode_val` mid-idle, and the scoreboard expects a full fresh idle count and the newly sampled word. A separate run pulls the asynchronous reset between clock edges and checks the outputs before the next edge arrives.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_IDLE  = 3'd1,
    ST_DUMMY = 3'd2,
    ST_VALID = 3'd3,
    ST_TRC   = 3'd4,
    ST_READY = 3'd5
  } init_state_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic ref_n;
  } dram_cmd_t;

  localparam dram_cmd_t CMD_DESEL = '{cs_n: 1'b1, we_n: 1'b1, ref_n: 1'b1};
  localparam dram_cmd_t CMD_NOP   = '{cs_n: 1'b0, we_n: 1'b1, ref_n: 1'b1};
  localparam dram_cmd_t CMD_MRS   = '{cs_n: 1'b0, we_n: 1'b0, ref_n: 1'b0};

endpackage

// File: rtl/dram_init_rst_sync.sv
module dram_init_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/dram_init_timer.sv
module dram_init_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (en && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/dram_init_fsm.sv
module dram_init_fsm
  import dram_init_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int CNT_W     = 16,
  parameter int IDLE_CYC  = 40000,
  parameter int NUM_DUMMY = 2,
  parameter int MRSC_CYC  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic [ADDR_W-1:0] mode_val,
  input  logic              tmr_zero,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              tmr_en,
  output init_state_e       state_d,
  output logic [ADDR_W-1:0] mode_q
);

  localparam logic [CNT_W-1:0] IDLE_LD  = CNT_W'(IDLE_CYC - 1);
  localparam logic [CNT_W-1:0] DUMMY_LD = CNT_W'(NUM_DUMMY - 1);
  localparam logic [CNT_W-1:0] MRSC_LD  = CNT_W'(MRSC_CYC - 1);

  init_state_e state_q;
  logic        mode_cap;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_en   = 1'b0;
    mode_cap = 1'b0;
    unique case (state_q)
      ST_WAIT: begin
        if (pwr_good) begin
          state_d  = ST_IDLE;
          tmr_load = 1'b1;
          tmr_val  = IDLE_LD;
          mode_cap = 1'b1;
        end
      end
      ST_IDLE: begin
        tmr_en = 1'b1;
        if (tmr_zero) begin
          state_d  = ST_DUMMY;
          tmr_load = 1'b1;
          tmr_val  = DUMMY_LD;
        end
      end
      ST_DUMMY: begin
        tmr_en = 1'b1;
        if (tmr_zero) begin
          state_d = ST_VALID;
        end
      end
      ST_VALID: begin
        state_d  = ST_TRC;
        tmr_load = 1'b1;
        tmr_val  = MRSC_LD;
      end
      ST_TRC: begin
        tmr_en = 1'b1;
        if (tmr_zero) begin
          state_d = ST_READY;
        end
      end
      ST_READY: state_d = ST_READY;
      default:  state_d = ST_WAIT;
    endcase
    if (!pwr_good) begin
      state_d  = ST_WAIT;
      tmr_load = 1'b0;
      mode_cap = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_cap) begin
      mode_q <= mode_val;
    end
  end

endmodule

// File: rtl/dram_init_out.sv
module dram_init_out
  import dram_init_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  init_state_e       state_d,
  input  logic [ADDR_W-1:0] mode_q,
  output dram_cmd_t         cmd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              done_q
);

  dram_cmd_t         cmd_d;
  logic [ADDR_W-1:0] addr_d;
  logic              done_d;

  always_comb begin
    cmd_d  = CMD_DESEL;
    addr_d = '0;
    done_d = 1'b0;
    unique case (state_d)
      ST_IDLE, ST_TRC: cmd_d = CMD_NOP;
      ST_DUMMY:        cmd_d = CMD_MRS;
      ST_VALID: begin
        cmd_d  = CMD_MRS;
        addr_d = mode_q;
      end
      ST_READY:        done_d = 1'b1;
      default:         cmd_d = CMD_DESEL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_DESEL;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int CLK_FREQ_MHZ = 200,
  parameter int IDLE_US      = 200,
  parameter int NUM_DUMMY    = 2,
  parameter int MRSC_CYCLES  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic [ADDR_W-1:0] mode_val,
  output logic              cs_n,
  output logic              we_n,
  output logic              ref_n,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int IDLE_CYC = CLK_FREQ_MHZ * IDLE_US;
  localparam int MAX_LD   = (IDLE_CYC > MRSC_CYCLES) ?
                            ((IDLE_CYC > NUM_DUMMY) ? IDLE_CYC : NUM_DUMMY) :
                            ((MRSC_CYCLES > NUM_DUMMY) ? MRSC_CYCLES : NUM_DUMMY);
  localparam int CNT_W    = $clog2(MAX_LD + 1);

  generate
    if (NUM_DUMMY < 2) begin : g_bad_dummy
      $error("dram_init_seq: NUM_DUMMY must be 2 or more");
    end
    if (MRSC_CYCLES < 1) begin : g_bad_mrsc
      $error("dram_init_seq: MRSC_CYCLES must be 1 or more");
    end
  endgenerate

  logic              rst_ns;
  logic              tmr_load;
  logic              tmr_en;
  logic              tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  init_state_e       state_d;
  logic [ADDR_W-1:0] mode_q;
  dram_cmd_t         cmd_q;

  dram_init_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  dram_init_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_ns),
    .load     (tmr_load),
    .load_val (tmr_val),
    .en       (tmr_en),
    .zero     (tmr_zero)
  );

  dram_init_fsm #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .IDLE_CYC  (IDLE_CYC),
    .NUM_DUMMY (NUM_DUMMY),
    .MRSC_CYC  (MRSC_CYCLES)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_ns),
    .pwr_good (pwr_good),
    .mode_val (mode_val),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .tmr_en   (tmr_en),
    .state_d  (state_d),
    .mode_q   (mode_q)
  );

  dram_init_out #(.ADDR_W(ADDR_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_ns),
    .state_d (state_d),
    .mode_q  (mode_q),
    .cmd_q   (cmd_q),
    .addr_q  (addr),
    .done_q  (init_done)
  );

  assign cs_n  = cmd_q.cs_n;
  assign we_n  = cmd_q.we_n;
  assign ref_n = cmd_q.ref_n;

endmodule

// File: rtl/dram_init_seq_chk.sv
module dram_init_seq_chk #(
  parameter int ADDR_W    = 14,
  parameter int NUM_DUMMY = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_good,
  input logic              cs_n,
  input logic              we_n,
  input logic              ref_n,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);

  logic       is_mrs;
  logic       is_nop;
  logic       prev_mrs_q;
  logic [7:0] run_q;

  assign is_mrs = !cs_n && !we_n && !ref_n;
  assign is_nop = !cs_n && we_n && ref_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_mrs_q <= 1'b0;
      run_q      <= '0;
    end else begin
      prev_mrs_q <= is_mrs;
      if (is_mrs) begin
        if (run_q != 8'hFF) run_q <= run_q + 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end

  // R2: only NOP or mode-register-set while selected
  assert_legal_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (we_n == ref_n));

  // R4: a non-zero address ends the burst (only the last command carries data)
  assert_dummy_addr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && (addr != '0)) |=> !is_mrs);

  // R4: a burst that ends holds at least the dummies plus the valid command
  assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_mrs && prev_mrs_q) |-> (32'(run_q) >= NUM_DUMMY + 1));

  // R6: init_done rises only after a NOP and never with the pins selected
  assert_done_after_nop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(is_nop));

  assert_done_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> cs_n);

  // R7: init_done is sticky while power is good
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && pwr_good) |=> init_done);

  // R8: power loss deselects on the following cycle
  assert_pwr_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (cs_n && !init_done));

endmodule

bind dram_init_seq dram_init_seq_chk #(
  .ADDR_W    (ADDR_W),
  .NUM_DUMMY (NUM_DUMMY)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_good  (pwr_good),
  .cs_n      (cs_n),
  .we_n      (we_n),
  .ref_n     (ref_n),
  .addr      (addr),
  .init_done (init_done)
);

// File: tb/dram_init_seq_bench.sv
`timescale 1ns/1ps
module dram_init_seq_bench;

  localparam int AW    = 14;
  localparam int FMHZ  = 200;
  localparam int IUS   = 2;
  localparam int NDUM  = 3;
  localparam int MRSC  = 4;
  localparam int IDLE  = FMHZ * IUS;

  typedef struct {
    logic          cs_n;
    logic          we_n;
    logic          ref_n;
    logic [AW-1:0] addr;
    logic          done;
    string         tag;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          pwr_good;
  logic [AW-1:0] mode_val;
  logic          cs_n, we_n, ref_n, init_done;
  logic [AW-1:0] addr;

  exp_t exp_q[$];
  int   n_tests;
  int   n_fail;
  bit   finished;

  dram_init_seq #(
    .ADDR_W(AW), .CLK_FREQ_MHZ(FMHZ), .IDLE_US(IUS),
    .NUM_DUMMY(NDUM), .MRSC_CYCLES(MRSC)
  ) u_dram_init_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .mode_val(mode_val),
    .cs_n(cs_n), .we_n(we_n), .ref_n(ref_n), .addr(addr), .init_done(init_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [AW+3:0] act, input logic [AW+3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got {cs,we,ref,addr,done}=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input logic c, input logic w, input logic r,
                      input logic [AW-1:0] a, input logic d, input string tag);
    exp_t e;
    e.cs_n = c; e.we_n = w; e.ref_n = r; e.addr = a; e.done = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Driver: raise power-good and queue the full expected command stream.
  task automatic start_seq(input logic [AW-1:0] mode);
    @(negedge clk); #1;
    mode_val = mode;
    for (int i = 0; i < IDLE; i++) push(1'b0, 1'b1, 1'b1, '0, 1'b0, "R3 idle NOP");
    for (int i = 0; i < NDUM; i++) push(1'b0, 1'b0, 1'b0, '0, 1'b0, "R4 dummy MRS");
    push(1'b0, 1'b0, 1'b0, mode, 1'b0, "R5 valid MRS");
    for (int i = 0; i < MRSC; i++) push(1'b0, 1'b1, 1'b1, '0, 1'b0, "R6 mrsc NOP");
    for (int i = 0; i < 8; i++) push(1'b1, 1'b1, 1'b1, '0, 1'b1, "R6 ready deselect");
    pwr_good = 1'b1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Monitor: pop one expected item per cycle and compare.
  always @(negedge clk) begin
    if (rst_n && !cs_n) begin
      check("R2 legal encoding", {3'b000, we_n, {AW{1'b0}}}, {3'b000, ref_n, {AW{1'b0}}});
    end
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, {cs_n, we_n, ref_n, addr, init_done},
                   {e.cs_n, e.we_n, e.ref_n, e.addr, e.done});
    end
  end

  localparam logic [AW+3:0] DESEL = {3'b111, {AW{1'b0}}, 1'b0};
  localparam logic [AW+3:0] READY = {3'b111, {AW{1'b0}}, 1'b1};

  initial begin
    n_tests = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; pwr_good = 1'b0; mode_val = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state", {cs_n, we_n, ref_n, addr, init_done}, DESEL);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 waiting without power-good", {cs_n, we_n, ref_n, addr, init_done}, DESEL);

    // Full sequence with a non-zero mode word.
    start_seq(14'h1A5);
    drain();
    repeat (20) @(negedge clk);
    check("R7 done held", {cs_n, we_n, ref_n, addr, init_done}, READY);

    // Power loss after ready.
    #1; pwr_good = 1'b0;
    @(negedge clk);
    check("R8 power loss after ready", {cs_n, we_n, ref_n, addr, init_done}, DESEL);
    repeat (3) @(negedge clk);

    // Restart; mode_val changes mid-idle must be ignored.
    start_seq(14'h2C3);
    repeat (100) @(negedge clk);
    #1; mode_val = 14'h3FF;
    drain();
    check("R5 captured mode ignored late change", {cs_n, we_n, ref_n, addr, init_done}, READY);

    // Abort mid-idle, then a fresh full sequence.
    #1; pwr_good = 1'b0;
    repeat (2) @(negedge clk);
    start_seq(14'h0F0);
    repeat (50) @(negedge clk);
    #1; exp_q.delete(); pwr_good = 1'b0;
    @(negedge clk);
    check("R8 power loss mid-idle", {cs_n, we_n, ref_n, addr, init_done}, DESEL);
    repeat (2) @(negedge clk);
    start_seq(14'h155);
    drain();

    // Asynchronous reset mid-sequence.
    #1; pwr_good = 1'b0;
    repeat (2) @(negedge clk);
    start_seq(14'h0AA);
    repeat (IDLE + 1) @(negedge clk);
    exp_q.delete();
    #1; rst_n = 1'b0;
    #0.5;
    check("R9 async reset mid-burst", {cs_n, we_n, ref_n, addr, init_done}, DESEL);
    pwr_good = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset release", {cs_n, we_n, ref_n, addr, init_done}, DESEL);

    // Mode word of zero: valid command looks like a dummy.
    start_seq(14'h000);
    drain();
    report();
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

endmodule